// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus and runs the one-time bring-up that must happen before normal traffic starts. After reset it keeps the clock-enable pin low and the command pins at NOP. It does this for a programmable number of stable-clock cycles. Then it raises clock-enable and walks a fixed list of commands: precharge-all, extended mode set (DLL on, drive strength), mode set with DLL reset, precharge-all, a programmable number of auto-refreshes, and a closing mode set that clears the DLL-reset bit. A dedicated gap timer sets the spacing after each command, and every delay is a parameter counted in clocks.

Two flags report progress. `init_done_o` rises once the closing mode set and its mode-register gap have passed. `read_ok_o` is driven by its own counter, which starts at the DLL-reset mode set and runs for the DLL-lock window. Reads must be held off until it rises, even if the rest of the sequence has already finished. Burst length, burst type, CAS latency and drive strength arrive as static configuration inputs and are packed into the mode words.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset release, `cke_o` stays low and the bus shows NOP for STABLE_CYC clock edges. On edge STABLE_CYC a NOP is driven and `cke_o` rises, and it never falls again until reset.
- R2: Each command is issued a set number of edges after the one before it. Precharge-all comes T_CKE edges after the CKE rise. The extended mode set follows T_RP later, and the DLL-reset mode set T_MRD after that. The second precharge-all follows T_MRD later and the first auto-refresh T_RP after it. There are N_REF auto-refreshes spaced T_RFC apart, and the final mode set comes T_RFC after the last refresh.
- R3: Command codes on {cs_n, ras_n, cas_n, we_n}: NOP 0111, precharge 0010, auto-refresh 0001, mode set 0000. A precharge-all drives address bit 8 high and every other address and bank bit low.
- R4: The extended mode set drives bank = 01 and address bit 0 = 0 (DLL enabled). Address bits 6 and 1 equal `drv_str_i[1]` and `drv_str_i[0]` (00 full, 01 half, 11 weak), and all other address bits are 0.
- R5: Both mode sets drive bank = 00, address[2:0] = `burst_len_i`, address[3] = `burst_type_i`, address[6:4] = `cas_lat_i` and address[7] = 0. Address bit 8 is 1 on the first mode set and 0 on the final one, and the upper bits are 0.
- R6: Every cycle without a listed command is a NOP. Once `init_done_o` is high, only NOPs are driven.
- R7: `init_done_o` rises T_MRD edges after the final mode set and stays high until reset.
- R8: `read_ok_o` rises DLL_LOCK edges after the DLL-reset mode set, whatever the state of `init_done_o`, and stays high until reset.
- R9: An asynchronous reset at any step immediately returns `cke_o` low, the bus to NOP and both flags low. After release the whole sequence restarts from the stable-clock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 3 | Burst-length code for the mode word |
| burst_type_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cas_lat_i | input | 3 | CAS-latency code for the mode word |
| drv_str_i | input | 2 | Drive-strength code placed on address bits 6 and 1 |
| cke_o | output | 1 | Clock enable to the memory |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | AW | Address bus / mode word |
| ba_o | output | BW | Bank address / mode register select |
| init_done_o | output | 1 | Sequence complete |
| read_ok_o | output | 1 | DLL-lock window elapsed, reads allowed |

## Verification
The sequence-done flag and the DLL-lock flag are driven by two independent counters, so they can rise on the same clock edge. The bench sets the lock window so that the lock count ends exactly on the edge where the final mode-set gap also expires. Both flags must then change together at that one sample, and neither may rise a cycle early or late. Each configuration vector is run through the whole sequence. A reset in the middle of the sequence shows that both counters restart from zero.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] ddr_cmd_t;
  localparam ddr_cmd_t CMD_NOP = 4'b0111;
  localparam ddr_cmd_t CMD_PRE = 4'b0010;
  localparam ddr_cmd_t CMD_REF = 4'b0001;
  localparam ddr_cmd_t CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_PREA1,
    ST_EMRS,
    ST_MRS_RST,
    ST_PREA2,
    ST_REF,
    ST_MRS_RUN,
    ST_DONE
  } init_step_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int TW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= TW'(RST_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2: spacing relies on one decrement per idle cycle
  assert_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == TW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word #(
  parameter int AW = 12,
  parameter int BW = 2
) (
  input  logic          ext_i,
  input  logic          dll_rst_i,
  input  logic [2:0]    burst_len_i,
  input  logic          burst_type_i,
  input  logic [2:0]    cas_lat_i,
  input  logic [1:0]    drv_str_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] ba_o
);
  always_comb begin
    addr_o = '0;
    ba_o   = '0;
    if (ext_i) begin
      ba_o[0]   = 1'b1;
      addr_o[6] = drv_str_i[1];
      addr_o[1] = drv_str_i[0];
    end else begin
      addr_o[2:0] = burst_len_i;
      addr_o[3]   = burst_type_i;
      addr_o[6:4] = cas_lat_i;
      addr_o[8]   = dll_rst_i;
    end
  end
endmodule

// File: rtl/ddr_dll_lock.sv
module ddr_dll_lock #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic locked_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic armed_q, zero;

  ddr_init_timer #(.TW(LW), .RST_VAL(0)) u_lock_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .load_val_i (LW'(LOCK_CYC - 1)),
    .zero_o     (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      if (start_i) armed_q <= 1'b1;
      if (armed_q && zero && !start_i) locked_o <= 1'b1;
    end
  end

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  assert_lock_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> armed_q);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int STABLE_CYC = 20000,
  parameter int T_CKE      = 2,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 19,
  parameter int N_REF      = 2,
  parameter int DLL_LOCK   = 200,
  parameter int AW         = 12,
  parameter int BW         = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    burst_len_i,
  input  logic          burst_type_i,
  input  logic [2:0]    cas_lat_i,
  input  logic [1:0]    drv_str_i,
  output logic          cke_o,
  output logic          cs_no,
  output logic          ras_no,
  output logic          cas_no,
  output logic          we_no,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] ba_o,
  output logic          init_done_o,
  output logic          read_ok_o
);
  localparam int MAX_GAP = max2(STABLE_CYC, max2(max2(T_CKE, T_RP), max2(T_MRD, T_RFC)));
  localparam int TW      = $clog2(MAX_GAP + 1);
  localparam int RW      = $clog2(N_REF + 1);

  init_step_e    step_q, step_d;
  logic [RW-1:0] ref_left_q;
  ddr_cmd_t      cmd_q, cmd_d;
  logic [AW-1:0] addr_d, mw_addr, pre_addr;
  logic [BW-1:0] ba_d, mw_ba;
  logic [TW-1:0] gap;
  logic          tmr_zero, issue, dll_start;

  assign issue     = tmr_zero && (step_q != ST_DONE);
  assign dll_start = issue && (step_q == ST_MRS_RST);

  ddr_init_timer #(.TW(TW), .RST_VAL(STABLE_CYC - 1)) u_gap_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (issue),
    .load_val_i (gap),
    .zero_o     (tmr_zero)
  );

  ddr_mode_word #(.AW(AW), .BW(BW)) u_mode_word (
    .ext_i        (step_q == ST_EMRS),
    .dll_rst_i    (step_q == ST_MRS_RST),
    .burst_len_i  (burst_len_i),
    .burst_type_i (burst_type_i),
    .cas_lat_i    (cas_lat_i),
    .drv_str_i    (drv_str_i),
    .addr_o       (mw_addr),
    .ba_o         (mw_ba)
  );

  ddr_dll_lock #(.LOCK_CYC(DLL_LOCK)) u_dll_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (dll_start),
    .locked_o (read_ok_o)
  );

  always_comb begin
    pre_addr    = '0;
    pre_addr[8] = 1'b1;
  end

  // command, word and following gap of the current step
  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    gap    = '0;
    step_d = step_q;
    unique case (step_q)
      ST_POWER:   begin gap = TW'(T_CKE - 1); step_d = ST_PREA1; end
      ST_PREA1:   begin cmd_d = CMD_PRE; addr_d = pre_addr; gap = TW'(T_RP - 1); step_d = ST_EMRS; end
      ST_EMRS:    begin cmd_d = CMD_MRS; addr_d = mw_addr; ba_d = mw_ba; gap = TW'(T_MRD - 1); step_d = ST_MRS_RST; end
      ST_MRS_RST: begin cmd_d = CMD_MRS; addr_d = mw_addr; ba_d = mw_ba; gap = TW'(T_MRD - 1); step_d = ST_PREA2; end
      ST_PREA2:   begin cmd_d = CMD_PRE; addr_d = pre_addr; gap = TW'(T_RP - 1); step_d = ST_REF; end
      ST_REF: begin
        cmd_d = CMD_REF;
        gap   = TW'(T_RFC - 1);
        if (ref_left_q == RW'(1)) step_d = ST_MRS_RUN;
      end
      ST_MRS_RUN: begin cmd_d = CMD_MRS; addr_d = mw_addr; ba_d = mw_ba; gap = TW'(T_MRD - 1); step_d = ST_DONE; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= ST_POWER;
      ref_left_q  <= RW'(N_REF);
      cmd_q       <= CMD_NOP;
      addr_o      <= '0;
      ba_o        <= '0;
      cke_o       <= 1'b0;
      init_done_o <= 1'b0;
    end else begin
      if (issue) begin
        step_q <= step_d;
        cmd_q  <= cmd_d;
        addr_o <= addr_d;
        ba_o   <= ba_d;
        cke_o  <= 1'b1;
        if (step_q == ST_REF) ref_left_q <= ref_left_q - 1'b1;
      end else begin
        cmd_q  <= CMD_NOP;
        addr_o <= '0;
        ba_o   <= '0;
      end
      if (step_q == ST_DONE && tmr_zero) init_done_o <= 1'b1;
    end
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;

  assert_cke_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
  assert_nop_cke_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (cmd_q == CMD_NOP));
  assert_prea_bit8_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> (addr_o[8] && ba_o == '0));
  assert_emrs_dll_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_MRS && ba_o[0]) |-> !addr_o[0]);
  assert_mrs_test_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_MRS && !ba_o[0]) |-> !addr_o[7]);
  assert_quiet_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (cmd_q == CMD_NOP));
  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  if (T_MRD >= 2) begin : g_mrd_chk
    assert_mrs_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
  end
endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
  localparam int STABLE = 50, TCKE = 2, TRP = 3, TMRD = 2, TRFC = 6, NREF = 2, LOCK = 19;
  localparam int K_CKE  = STABLE;
  localparam int K_PRE1 = K_CKE + TCKE;
  localparam int K_EMRS = K_PRE1 + TRP;
  localparam int K_MRS1 = K_EMRS + TMRD;
  localparam int K_PRE2 = K_MRS1 + TMRD;
  localparam int K_REF0 = K_PRE2 + TRP;
  localparam int K_MRS2 = K_REF0 + NREF * TRFC;
  localparam int K_DONE = K_MRS2 + TMRD;
  localparam int K_LOCK = K_MRS1 + LOCK;
  localparam int K_END  = K_DONE + 8;

  // {burst_len[2:0], burst_type, cas_lat[2:0], drv[1:0]}
  localparam logic [8:0] CFG_TAB [4] = '{
    {3'b001, 1'b0, 3'b100, 2'b00},
    {3'b010, 1'b1, 3'b101, 2'b01},
    {3'b011, 1'b0, 3'b101, 2'b11},
    {3'b011, 1'b1, 3'b100, 2'b01}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] bl = '0, cl = '0;
  logic bt = 1'b0;
  logic [1:0] drv = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, done, rd_ok;
  logic [11:0] addr;
  logic [1:0] ba;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ddr_init_seq #(.STABLE_CYC(STABLE), .T_CKE(TCKE), .T_RP(TRP), .T_MRD(TMRD),
                 .T_RFC(TRFC), .N_REF(NREF), .DLL_LOCK(LOCK)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .burst_len_i(bl), .burst_type_i(bt),
    .cas_lat_i(cl), .drv_str_i(drv), .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n),
    .cas_no(cas_n), .we_no(we_n), .addr_o(addr), .ba_o(ba),
    .init_done_o(done), .read_ok_o(rd_ok));

  task automatic chk(input string req, input int k, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d act=%h exp=%h", req, k, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // expected bus contents after edge k
  task automatic expect_at(input int k, output logic [3:0] c, output logic [11:0] a,
                           output logic [1:0] b, output string tag);
    c = 4'b0111; a = '0; b = '0; tag = "R6";
    if (k == K_PRE1 || k == K_PRE2) begin
      c = 4'b0010; a[8] = 1'b1; tag = "R3";
    end else if (k == K_EMRS) begin
      c = 4'b0000; b = 2'b01; a[6] = drv[1]; a[1] = drv[0]; tag = "R4";
    end else if (k == K_MRS1 || k == K_MRS2) begin
      c = 4'b0000; a[2:0] = bl; a[3] = bt; a[6:4] = cl; a[8] = (k == K_MRS1); tag = "R5";
    end else if (k >= K_REF0 && k < K_MRS2 && ((k - K_REF0) % TRFC) == 0) begin
      c = 4'b0001; tag = "R2";
    end
  endtask

  task automatic start_run(input int idx);
    rst_ni = 1'b0;
    {bl, bt, cl, drv} = CFG_TAB[idx];
    @(negedge clk); @(negedge clk);
    chk("R1 reset cke", 0, cke, 0);
    chk("R1 reset cmd", 0, {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R7 reset done", 0, done, 0);
    chk("R8 reset rd_ok", 0, rd_ok, 0);
    rst_ni = 1'b1;
  endtask

  task automatic walk(input int kmax, input string pfx);
    logic [3:0] c; logic [11:0] a; logic [1:0] b; string tag;
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      expect_at(k, c, a, b, tag);
      chk({pfx, " R1 cke"}, k, cke, (k >= K_CKE));
      chk({pfx, " ", (c == 4'b0111) ? "R6" : "R2", " cmd"}, k, {cs_n, ras_n, cas_n, we_n}, c);
      if (c != 4'b0111) chk({pfx, " ", tag, " word"}, k, {ba, addr}, {b, a});
      chk({pfx, " R7 done"}, k, done, (k >= K_DONE));
      chk({pfx, " R8 rd_ok"}, k, rd_ok, (k >= K_LOCK));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      start_run(i);
      walk(K_END, "vec");
    end
    // R9: abort mid-refresh, check async clear, then full replay
    start_run(1);
    walk(K_REF0 + 1, "R9 pre");
    #2 rst_ni = 1'b0;
    #1;
    chk("R9 async cke", 0, cke, 0);
    chk("R9 async cmd", 0, {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R9 async flags", 0, {done, rd_ok}, 2'b00);
    start_run(2);
    walk(K_END, "R9 replay");
    finished = 1'b1;
    report();
  end
endmodule